// File: doc/BRIEF.md
# Dual-slope conversion sequencer

This block is the digital half of an integrating analog-to-digital converter. After a start strobe it closes the integrator discharge switch for a set number of clock cycles. It then connects the unknown input for a fixed number of cycles, N1, chosen as whole periods of the power line. Finally it connects the negative reference and counts clock cycles until the comparator reports that the integrator output is no longer positive. The count is the conversion result. Both phases use one clock, so the result depends only on the ratio of input to reference, `result = N1 * Vin / Vref`, rounded up to whole cycles.

The comparator input passes through a two-flop synchroniser. The sequencer removes that fixed lag from the count. If the count passes 2*N1 without a crossing, the conversion ends with an overrange flag and a full-scale code. The integrator is then discharged again before the sequencer returns to idle. N1 is `CYC_PER_LINE * LINE_MULT`.

Top module: `dual_slope_seq`

## Requirements
- R1: A synchronous active-low reset puts the sequencer in idle. All three selects are low, `done` is low, `ovr` is 0 and `result` is 0.
- R2: An accepted start raises `sel_zero` in the next cycle and holds it for exactly ZERO_CYC cycles. `sel_in` follows directly afterwards.
- R3: `sel_in` is high for exactly N1 = CYC_PER_LINE*LINE_MULT consecutive cycles. `sel_ref` follows directly afterwards.
- R4: At most one of `sel_zero`, `sel_in` and `sel_ref` is high in any cycle. None is high in idle or in the `done` cycle.
- R5: `cmp_in` high means the integrator is positive. The k-th deintegration edge is the k-th rising clock edge with `sel_ref` high. Suppose `cmp_in` is first seen low in the cycle after the k-th deintegration edge, with k ≤ 2*N1. Then `result` = k, `ovr` = 0, and `sel_ref` stays high for k+3 cycles.
- R6: If `cmp_in` is already low when deintegration starts (zero or negative input), `result` = 0 and `sel_ref` lasts 3 cycles.
- R7: If no crossing occurs within k ≤ 2*N1, the conversion stops after 2*N1+3 cycles of `sel_ref`. `ovr` becomes 1 and `result` becomes all ones.
- R8: After an overrange, `sel_zero` is high for ZERO_CYC cycles and the sequencer then returns to idle without raising `sel_in`.
- R9: `done` is a one-cycle pulse in the cycle where the new `result` and `ovr` first appear. `result` changes at no other time.
- R10: A start strobe during a conversion is ignored. The phase lengths and the result are unchanged, and only one `done` is issued.
- R11: `ovr` is cleared when the next start is accepted, so it is 0 during that conversion's first discharge cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both timing phases |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion request, accepted only in idle |
| cmp_in | input | 1 | Comparator, high while integrator output is positive |
| sel_zero | output | 1 | Integrator discharge switch select |
| sel_in | output | 1 | Unknown-input switch select |
| sel_ref | output | 1 | Negative-reference switch select |
| result | output | RES_W | Conversion count, all ones on overrange |
| done | output | 1 | One-cycle pulse marking a new result |
| ovr | output | 1 | Overrange flag of the last conversion |

## Verification
The hardest cases sit exactly on the edges of the deintegration window. One is a crossing at k = 2*N1, which must still give a valid result. Another is k = 2*N1+1, which must give overrange. A third is a comparator that is low before deintegration begins. The bench reaches all three through a behavioural integrator. This model is a signed accumulator driven by the select outputs. The input-to-reference ratios are chosen so that the ceiling of N1*Vin/Vref falls on 0, 80, 81 and beyond.

// File: rtl/dual_slope_seq.sv
module dual_slope_seq #(
  parameter int CYC_PER_LINE = 20,
  parameter int LINE_MULT    = 2,
  parameter int ZERO_CYC     = 4,
  localparam int N1    = CYC_PER_LINE * LINE_MULT,
  localparam int RES_W = $clog2(2 * N1 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_in,
  output logic             sel_zero,
  output logic             sel_in,
  output logic             sel_ref,
  output logic [RES_W-1:0] result,
  output logic             done,
  output logic             ovr
);
  localparam int SYNC  = 2;
  localparam int LIMIT = 2 * N1 + SYNC;
  localparam int CMAX  = (ZERO_CYC > LIMIT) ? ZERO_CYC : LIMIT;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] Z_LAST = CNT_W'(ZERO_CYC - 1);
  localparam logic [CNT_W-1:0] I_LAST = CNT_W'(N1 - 1);
  localparam logic [CNT_W-1:0] D_MAX  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] D_LAT  = CNT_W'(SYNC);

  typedef enum logic [2:0] {S_IDLE, S_ZERO, S_INTEG, S_DEINT, S_DONE} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       sy;
  logic [CNT_W-1:0] n2;

  assign n2       = cnt - D_LAT;
  assign sel_zero = (state == S_ZERO);
  assign sel_in   = (state == S_INTEG);
  assign sel_ref  = (state == S_DEINT);
  assign done     = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sy     <= '0;
      result <= '0;
      ovr    <= 1'b0;
    end else begin
      sy <= {sy[0], cmp_in};
      case (state)
        S_IDLE: if (start) begin
          state <= S_ZERO;
          cnt   <= '0;
          ovr   <= 1'b0;
        end
        S_ZERO: if (cnt == Z_LAST) begin
          cnt   <= '0;
          state <= ovr ? S_IDLE : S_INTEG;
        end else cnt <= cnt + 1'b1;
        S_INTEG: if (cnt == I_LAST) begin
          cnt   <= '0;
          state <= S_DEINT;
        end else cnt <= cnt + 1'b1;
        S_DEINT: if (cnt >= D_LAT && !sy[1]) begin
          result <= RES_W'(n2);
          state  <= S_DONE;
        end else if (cnt == D_MAX) begin
          result <= '1;
          ovr    <= 1'b1;
          state  <= S_DONE;
        end else cnt <= cnt + 1'b1;
        S_DONE: begin
          cnt   <= '0;
          state <= ovr ? S_ZERO : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int RES_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cmp_in,
  input logic             sel_zero,
  input logic             sel_in,
  input logic             sel_ref,
  input logic [RES_W-1:0] result,
  input logic             done,
  input logic             ovr
);
  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_zero, sel_in, sel_ref}));
  // R4
  done_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(sel_zero || sel_in || sel_ref));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(result)));
  // R2
  in_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_in) |-> $past(sel_zero));
  // R3
  ref_after_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_ref) |-> $past(sel_in));
  // R7
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovr) |-> (result == {RES_W{1'b1}}));
endmodule

bind dual_slope_seq dual_slope_seq_chk #(.RES_W(RES_W)) chk_i (.*);

// File: tb/dual_slope_seq_tb_top.sv
module dual_slope_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N1    = 40;
  localparam int ZC    = 4;
  localparam int RES_W = 7;
  localparam int NV    = 11;
  // vin, vref, expected result, expected overrange
  localparam int VEC [NV][4] = '{
    '{10, 10, 40, 0}, '{5, 10, 20, 0}, '{0, 10, 0, 0}, '{1, 40, 1, 0},
    '{3, 7, 18, 0},   '{20, 10, 80, 0}, '{81, 40, 0, 1}, '{-5, 10, 0, 0},
    '{30, 10, 0, 1},  '{79, 40, 79, 0}, '{7, 3, 0, 1}
  };

  logic clk = 0, rst_n = 0, start = 0, cmp_in = 0;
  logic sel_zero, sel_in, sel_ref, done, ovr;
  logic [RES_W-1:0] result;
  int tests = 0, fails = 0, cyc = 0;
  int acc = 0, vin = 0, vref = 1;

  dual_slope_seq #(.CYC_PER_LINE(20), .LINE_MULT(2), .ZERO_CYC(ZC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
    .sel_zero(sel_zero), .sel_in(sel_in), .sel_ref(sel_ref),
    .result(result), .done(done), .ovr(ovr));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (sel_zero) acc <= 0;
    else if (sel_in) acc <= acc + vin;
    else if (sel_ref) acc <= acc - vref;
  end
  always @(negedge clk) cmp_in = (acc > 0);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int vi, input int vr, input bit inj,
                          output int r, output int o, output int nz,
                          output int ni, output int nr, output int nd);
    int guard = 0;
    bit multi = 0;
    bit first = 1;
    vin = vi; vref = vr; nz = 0; ni = 0; nr = 0; nd = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (guard < 2000) begin
      if (first) begin
        chk("R11 ovr cleared on start", int'(ovr), 0);
        first = 0;
      end
      if ($countones({sel_zero, sel_in, sel_ref}) > 1) multi = 1;
      if (sel_zero) nz++;
      if (sel_in) ni++;
      if (sel_ref) nr++;
      if (done) begin
        nd++;
        break;
      end
      start = (inj && ni == 10);
      @(negedge clk);
      guard++;
    end
    start = 0;
    chk("R4 one select at a time", int'(multi), 0);
    chk("R4 selects open with done",
        int'(sel_zero || sel_in || sel_ref), 0);
    r = int'(result);
    o = int'(ovr);
  endtask

  initial begin
    int r, o, nz, ni, nr, nd, zc2, rise;
    repeat (3) @(negedge clk);
    chk("R1 reset selects", int'({sel_zero, sel_in, sel_ref}), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset ovr", int'(ovr), 0);
    chk("R1 reset result", int'(result), 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_conv(VEC[i][0], VEC[i][1], (i == 1), r, o, nz, ni, nr, nd);
      chk("R2 discharge length", nz, ZC);
      chk("R3 integrate length", ni, N1);
      chk("R1 done seen", nd, 1);
      if (VEC[i][3] != 0) begin
        chk("R7 overrange flag", o, 1);
        chk("R7 full scale", r, (1 << RES_W) - 1);
        chk("R7 deintegrate length", nr, 2 * N1 + 3);
      end else begin
        chk(VEC[i][2] == 0 ? "R6 zero result" : "R5 result", r, VEC[i][2]);
        chk("R5 overrange clear", o, 0);
        chk("R5 deintegrate length", nr, VEC[i][2] + 3);
      end
      @(negedge clk);
      chk("R9 done one cycle", int'(done), 0);
      chk("R9 result held", int'(result), r);
      if (i == 1) chk("R10 no second conversion", int'(sel_zero), 0);
      if (o != 0) begin
        zc2 = 0; rise = 0;
        for (int c = 0; c < 20; c++) begin
          if (sel_zero) zc2++;
          if (sel_in || sel_ref) rise = 1;
          @(negedge clk);
        end
        chk("R8 discharge after overrange", zc2, ZC);
        chk("R8 no integrate after overrange", rise, 0);
      end
      repeat (2) @(negedge clk);
    end

    // R10: start held across a whole conversion is ignored after acceptance
    vin = 10; vref = 10;
    @(negedge clk) start = 1;
    nd = 0; ni = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (sel_in) ni++;
      if (done) begin
        nd++;
        break;
      end
    end
    start = 0;
    chk("R10 held start integrate length", ni, N1);
    chk("R10 held start result", int'(result), 40);
    repeat (30) @(negedge clk);

    // R1: reset in the middle of integration
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (10) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1 mid reset selects", int'({sel_zero, sel_in, sel_ref}), 0);
    chk("R1 mid reset result", int'(result), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", int'({sel_zero, sel_in, sel_ref}), 0);
    run_conv(5, 10, 0, r, o, nz, ni, nr, nd);
    chk("R5 result after reset", r, 20);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule